// File: doc/BRIEF.md
# Processor Control Register Side-Effect Unit

This block holds a processor's control, debug and status registers, and it applies the architectural side effects that a write to one of them implies. It has one write port (strobe, index and data) and one combinational read port (index and data). Software-visible state covers the following:

- control registers 0, 2, 3, 4 and 8;
- an extended-feature register with a long-mode enable bit and a long-mode active bit;
- eight debug register indexes;
- a time-stamp offset;
- a floating-point status word and a separate three-bit stack-top field.

A write can change a bit in another register. It can also mask fields out, or request a flush of the address translation buffers. The flush request appears on one of two registered pulse outputs.

A derived mode word is computed combinationally from the following:

- the long-mode active bit;
- the protection-enable and paging bits of control register 0;
- the code-segment and stack-segment attribute inputs;
- the virtual-8086 flag input.

It gives the operating submode, the privilege level and the default and alternate operand, address and stack sizes. The same word is readable through an index.

The flush requests come from a small sequencer with three states:

- `FL_QUIET`: no request.
- `FL_FULL`: full flush pulse.
- `FL_PART`: non-global flush pulse.

The sequencer moves on every clock:

- It goes to `FL_FULL` when the accepted write asks for a full flush.
- Otherwise it goes to `FL_PART` when the write targets control register 3.
- Otherwise it goes to `FL_QUIET`.

A held state therefore lasts exactly one cycle per qualifying write.

Top module: `ctlreg_unit`

## Requirements
- R1: After reset every register reads zero, with two exceptions. Debug register 6 (index 22) reads 0xFFFF0FF0 and debug register 7 (index 23) reads 0x00000400. Both flush outputs are low after reset.
- R2: A write to control register 0 (index 0) stores the data with bit 4 forced to 1. If the write changes bit 31 (paging) while bit 8 of the extended-feature register (index 24) is set, bit 10 of that register takes the new bit 31. Otherwise bit 10 is left alone.
- R3: A write to index 0 that changes bit 31 raises `flush_all` for exactly one cycle, in the cycle after the write. A write to index 0 that keeps bit 31 raises no flush.
- R4: Every write to control register 3 (index 3) raises `flush_nonglobal` for one cycle in the next cycle, even when the value is unchanged.
- R5: A write to control register 4 (index 4) raises `flush_all` in the next cycle only if it toggles bit 4, bit 5 or bit 7. Changes to other bits cause no flush.
- R6: Indexes 1, 5 to 7, 9 to 15 and 29 to 31 are illegal.
  - A write to one of them raises `wr_err` while the strobe is high, changes no register and raises no flush.
  - A read of one of them raises `rd_err` and returns zero.
- R7: Debug indexes 16 to 19 are plain storage. Index 20 aliases index 22, and index 21 aliases index 23.
  - A write to debug register 6 changes only bits 0 to 3 and 13 to 15.
  - A write to debug register 7 changes only bits 0 to 7, bit 13 and bits 16 to 31.
- R8: A write of V to the time-stamp index (25) while `cyc_now` equals C stores V−C. A read at index 25 returns the stored value plus the present `cyc_now`, modulo 2^DW.
- R9: A read of the status word (index 26) returns the stored word with bits 13:11 replaced by the stack-top field. The stack-top field (index 27) keeps the low three bits of a write and reads back zero-extended.
- R10: The mode word (`mode_word`, also index 28) has the submode in bits 2:0, encoded as follows:
  - real = 0;
  - virtual-8086 = 1;
  - protected = 2;
  - compatibility = 3;
  - 64-bit = 4.

  The submode is chosen as follows:
  - With bit 10 of index 24 set, `cs_long` picks 64-bit, else compatibility.
  - Otherwise, with CR0 bit 0 clear the submode is real.
  - Otherwise `vm_flag` picks virtual-8086, else protected.

  Bit 3 of the mode word is the active bit.
- R11: The size fields use 1=16-bit, 2=32-bit and 3=64-bit. They are default operand [9:8], alternate operand [11:10], default address [13:12], alternate address [15:14] and stack [17:16].
  - In 64-bit mode the values are 2, 1, 3, 2 and 3.
  - Otherwise `cs_dsize` set gives operand 2/1 and address 2/1, and clear gives 1/2 and 1/2.
  - Outside 64-bit mode, the stack size is 2 if `ss_dsize` is set, else 1.
- R12: Mode word bits 5:4 equal `cs_dpl`, bit 6 equals CR0 bit 31 and bit 7 equals CR0 bit 0. A write to index 28 discards its data and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write register index |
| wr_data | input | DW | Write data |
| rd_idx | input | 5 | Read register index |
| rd_data | output | DW | Read data (combinational) |
| cyc_now | input | DW | Current cycle count |
| cs_long | input | 1 | Code-segment 64-bit attribute |
| cs_dsize | input | 1 | Code-segment default-size attribute |
| cs_dpl | input | 2 | Code-segment privilege level |
| ss_dsize | input | 1 | Stack-segment default-size attribute |
| vm_flag | input | 1 | Virtual-8086 flag |
| flush_all | output | 1 | Full translation flush request pulse |
| flush_nonglobal | output | 1 | Non-global translation flush request pulse |
| wr_err | output | 1 | Illegal write index |
| rd_err | output | 1 | Illegal read index |
| mode_word | output | 18 | Derived mode word |

## Verification
The bench builds the block with DW at its default of 32. At that width the paging bit is the top data bit and the whole upper half of debug register 6 is fixed. At that width the time-stamp offset also wraps within reach of small written values: a value smaller than the cycle count leaves a negative offset, and that offset must come back correct on read. Every submode and every code-segment and stack-segment size combination is reached by driving the attribute inputs against a register state that was built up by writes.

// File: rtl/ctlreg_pkg.sv
`timescale 1ns/1ps
package ctlreg_pkg;
    localparam int IDX_W = 5;

    localparam logic [IDX_W-1:0] IX_CR0  = 5'd0;
    localparam logic [IDX_W-1:0] IX_CR2  = 5'd2;
    localparam logic [IDX_W-1:0] IX_CR3  = 5'd3;
    localparam logic [IDX_W-1:0] IX_CR4  = 5'd4;
    localparam logic [IDX_W-1:0] IX_CR8  = 5'd8;
    localparam logic [IDX_W-1:0] IX_DR0  = 5'd16;
    localparam logic [IDX_W-1:0] IX_DR4  = 5'd20;
    localparam logic [IDX_W-1:0] IX_DR5  = 5'd21;
    localparam logic [IDX_W-1:0] IX_DR6  = 5'd22;
    localparam logic [IDX_W-1:0] IX_DR7  = 5'd23;
    localparam logic [IDX_W-1:0] IX_EXT  = 5'd24;
    localparam logic [IDX_W-1:0] IX_TSC  = 5'd25;
    localparam logic [IDX_W-1:0] IX_FSW  = 5'd26;
    localparam logic [IDX_W-1:0] IX_FTOP = 5'd27;
    localparam logic [IDX_W-1:0] IX_MODE = 5'd28;

    localparam int EXT_LME     = 8;
    localparam int EXT_LMA     = 10;
    localparam int CR0_PE      = 0;
    localparam int CR0_ET      = 4;
    localparam int CR0_PG      = 31;
    localparam int FSW_TOP_LSB = 11;
    localparam int TOP_W       = 3;

    localparam logic [31:0] CR4_FLUSH_MASK = 32'h0000_00B0;
    localparam logic [31:0] DR6_WMASK      = 32'h0000_E00F;
    localparam logic [31:0] DR7_WMASK      = 32'hFFFF_20FF;
    localparam logic [31:0] DR6_RST        = 32'hFFFF_0FF0;
    localparam logic [31:0] DR7_RST        = 32'h0000_0400;

    typedef enum logic [2:0] {
        SM_REAL   = 3'd0,
        SM_V86    = 3'd1,
        SM_PROT   = 3'd2,
        SM_COMPAT = 3'd3,
        SM_64     = 3'd4
    } submode_e;

    typedef enum logic [1:0] {
        FL_QUIET = 2'd0,
        FL_FULL  = 2'd1,
        FL_PART  = 2'd2
    } flush_e;

    typedef struct packed {
        logic [1:0] stack;
        logic [1:0] alt_addr;
        logic [1:0] def_addr;
        logic [1:0] alt_op;
        logic [1:0] def_op;
        logic       pe;
        logic       pg;
        logic [1:0] cpl;
        logic       is_long;
        submode_e   sub;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    function automatic logic idx_legal(input logic [IDX_W-1:0] i);
        return (i == IX_CR0) || (i == IX_CR2) || (i == IX_CR3) ||
               (i == IX_CR4) || (i == IX_CR8) ||
               ((i >= IX_DR0) && (i <= IX_MODE));
    endfunction
endpackage

// File: rtl/ctlreg_mode_calc.sv
`timescale 1ns/1ps
module ctlreg_mode_calc
    import ctlreg_pkg::*;
(
    input  logic       lma,
    input  logic       pe,
    input  logic       pg,
    input  logic       cs_long,
    input  logic       cs_dsize,
    input  logic [1:0] cs_dpl,
    input  logic       ss_dsize,
    input  logic       vm_flag,
    output mode_t      mode
);
    submode_e sub;
    logic     is64;

    always_comb begin
        if (lma)
            sub = cs_long ? SM_64 : SM_COMPAT;
        else if (!pe)
            sub = SM_REAL;
        else
            sub = vm_flag ? SM_V86 : SM_PROT;
    end

    assign is64 = (sub == SM_64);

    always_comb begin
        mode         = '0;
        mode.sub     = sub;
        mode.is_long = lma;
        mode.cpl     = cs_dpl;
        mode.pg      = pg;
        mode.pe      = pe;
        if (is64 || cs_dsize) begin
            mode.def_op = 2'd2;
            mode.alt_op = 2'd1;
        end else begin
            mode.def_op = 2'd1;
            mode.alt_op = 2'd2;
        end
        if (is64) begin
            mode.def_addr = 2'd3;
            mode.alt_addr = 2'd2;
            mode.stack    = 2'd3;
        end else begin
            mode.def_addr = cs_dsize ? 2'd2 : 2'd1;
            mode.alt_addr = cs_dsize ? 2'd1 : 2'd2;
            mode.stack    = ss_dsize ? 2'd2 : 2'd1;
        end
    end
endmodule

// File: rtl/ctlreg_flush_fsm.sv
`timescale 1ns/1ps
module ctlreg_flush_fsm
    import ctlreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_full,
    input  logic req_part,
    output logic flush_all,
    output logic flush_nonglobal
);
    flush_e state_q, state_d;

    always_comb begin
        if (req_full)
            state_d = FL_FULL;
        else if (req_part)
            state_d = FL_PART;
        else
            state_d = FL_QUIET;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= FL_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        flush_all       = 1'b0;
        flush_nonglobal = 1'b0;
        unique case (state_q)
            FL_QUIET: ;
            FL_FULL:  flush_all = 1'b1;
            FL_PART:  flush_nonglobal = 1'b1;
            default:  ;
        endcase
    end

    assert_full_from_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |-> $past(req_full));
    assert_part_from_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_part && !req_full |=> flush_nonglobal);
endmodule

// File: rtl/ctlreg_unit.sv
`timescale 1ns/1ps
module ctlreg_unit
    import ctlreg_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic [4:0]        rd_idx,
    output logic [DW-1:0]     rd_data,
    input  logic [DW-1:0]     cyc_now,
    input  logic              cs_long,
    input  logic              cs_dsize,
    input  logic [1:0]        cs_dpl,
    input  logic              ss_dsize,
    input  logic              vm_flag,
    output logic              flush_all,
    output logic              flush_nonglobal,
    output logic              wr_err,
    output logic              rd_err,
    output logic [17:0]       mode_word
);
    localparam logic [DW-1:0] M_CR4F  = DW'(CR4_FLUSH_MASK);
    localparam logic [DW-1:0] M_DR6   = DW'(DR6_WMASK);
    localparam logic [DW-1:0] M_DR7   = DW'(DR7_WMASK);
    localparam logic [DW-1:0] R_DR6   = DW'(DR6_RST);
    localparam logic [DW-1:0] R_DR7   = DW'(DR7_RST);
    localparam logic [DW-1:0] M_FTOP  = DW'({TOP_W{1'b1}}) << FSW_TOP_LSB;
    localparam int            N_PLAIN = 4;

    logic [DW-1:0] cr0_q, cr2_q, cr3_q, cr4_q, cr8_q, ext_q;
    logic [DW-1:0] dr_lo_q [N_PLAIN];
    logic [DW-1:0] dr6_q, dr7_q, tsc_off_q, fsw_q;
    logic [TOP_W-1:0] top_q;

    logic wr_ok, pg_toggle, cr4_hit, req_full, req_part;
    mode_t mode;

    assign wr_err    = wr_en && !idx_legal(wr_idx);
    assign rd_err    = !idx_legal(rd_idx);
    assign wr_ok     = wr_en && idx_legal(wr_idx);
    assign pg_toggle = cr0_q[CR0_PG] ^ wr_data[CR0_PG];
    assign cr4_hit   = |((cr4_q ^ wr_data) & M_CR4F);
    assign req_full  = wr_ok && (((wr_idx == IX_CR0) && pg_toggle) ||
                                 ((wr_idx == IX_CR4) && cr4_hit));
    assign req_part  = wr_ok && (wr_idx == IX_CR3);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr0_q <= '0; cr2_q <= '0; cr3_q <= '0; cr4_q <= '0; cr8_q <= '0;
            ext_q <= '0; tsc_off_q <= '0; fsw_q <= '0; top_q <= '0;
            dr6_q <= R_DR6; dr7_q <= R_DR7;
            for (int k = 0; k < N_PLAIN; k++) dr_lo_q[k] <= '0;
        end else if (wr_ok) begin
            case (wr_idx)
                IX_CR0: begin
                    cr0_q <= wr_data | (DW'(1) << CR0_ET);
                    if (pg_toggle && ext_q[EXT_LME])
                        ext_q[EXT_LMA] <= wr_data[CR0_PG];
                end
                IX_CR2:  cr2_q <= wr_data;
                IX_CR3:  cr3_q <= wr_data;
                IX_CR4:  cr4_q <= wr_data;
                IX_CR8:  cr8_q <= wr_data;
                5'd16, 5'd17, 5'd18, 5'd19:
                    dr_lo_q[wr_idx[1:0]] <= wr_data;
                IX_DR4, IX_DR6: dr6_q <= (dr6_q & ~M_DR6) | (wr_data & M_DR6);
                IX_DR5, IX_DR7: dr7_q <= (dr7_q & ~M_DR7) | (wr_data & M_DR7);
                IX_EXT:  ext_q <= wr_data;
                IX_TSC:  tsc_off_q <= wr_data - cyc_now;
                IX_FSW:  fsw_q <= wr_data;
                IX_FTOP: top_q <= wr_data[TOP_W-1:0];
                default: ;
            endcase
        end
    end

    ctlreg_mode_calc u_mode (
        .lma      (ext_q[EXT_LMA]),
        .pe       (cr0_q[CR0_PE]),
        .pg       (cr0_q[CR0_PG]),
        .cs_long  (cs_long),
        .cs_dsize (cs_dsize),
        .cs_dpl   (cs_dpl),
        .ss_dsize (ss_dsize),
        .vm_flag  (vm_flag),
        .mode     (mode)
    );
    assign mode_word = mode;

    ctlreg_flush_fsm u_flush (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_full        (req_full),
        .req_part        (req_part),
        .flush_all       (flush_all),
        .flush_nonglobal (flush_nonglobal)
    );

    always_comb begin
        rd_data = '0;
        if (rd_idx[4:2] == 3'b100) begin
            rd_data = dr_lo_q[rd_idx[1:0]];
        end else begin
            case (rd_idx)
                IX_CR0:         rd_data = cr0_q;
                IX_CR2:         rd_data = cr2_q;
                IX_CR3:         rd_data = cr3_q;
                IX_CR4:         rd_data = cr4_q;
                IX_CR8:         rd_data = cr8_q;
                IX_DR4, IX_DR6: rd_data = dr6_q;
                IX_DR5, IX_DR7: rd_data = dr7_q;
                IX_EXT:         rd_data = ext_q;
                IX_TSC:         rd_data = tsc_off_q + cyc_now;
                IX_FSW:         rd_data = (fsw_q & ~M_FTOP) | (DW'(top_q) << FSW_TOP_LSB);
                IX_FTOP:        rd_data = DW'(top_q);
                IX_MODE:        rd_data = DW'(mode_word);
                default:        rd_data = '0;
            endcase
        end
    end

    assert_lma_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wr_idx == IX_CR0 && pg_toggle && ext_q[EXT_LME])
        |=> (ext_q[EXT_LMA] == $past(wr_data[CR0_PG])));
    assert_et_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wr_idx == IX_CR0) |=> cr0_q[CR0_ET]);
    assert_cr3_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wr_idx == IX_CR3) |=> flush_nonglobal);
    assert_illegal_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> ($stable(cr0_q) && $stable(ext_q) && !flush_all && !flush_nonglobal));
    assert_dr6_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((dr6_q & ~M_DR6) == $past(dr6_q & ~M_DR6)));
    assert_stack64_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.sub == SM_64) |-> (mode.stack == 2'd3 && mode.def_addr == 2'd3));
    assert_flush_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_all, flush_nonglobal}));
endmodule

// File: tb/sim_ctlreg_unit.sv
`timescale 1ns/1ps
module sim_ctlreg_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [31:0] cyc_now = '0;
    logic        cs_long = 1'b0, cs_dsize = 1'b0, ss_dsize = 1'b0, vm_flag = 1'b0;
    logic [1:0]  cs_dpl = '0;
    logic        flush_all, flush_nonglobal, wr_err, rd_err;
    logic [17:0] mode_word;

    int n_cmp = 0;
    int n_bad = 0;
    logic [5:0]  g_seg = '0;
    logic [31:0] g_cyc = '0;

    typedef struct {
        string       tag;
        logic [31:0] rd;
        logic        fa, fn, we, re;
    } item_t;
    item_t q[$];

    localparam logic [5:0] S0    = 6'b000000;
    localparam logic [5:0] S64   = 6'b001101;
    localparam logic [5:0] SCOMP = 6'b010010;
    localparam logic [5:0] SV86  = 6'b100000;

    always #10 clk = ~clk;

    ctlreg_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .cyc_now(cyc_now),
        .cs_long(cs_long), .cs_dsize(cs_dsize), .cs_dpl(cs_dpl), .ss_dsize(ss_dsize),
        .vm_flag(vm_flag), .flush_all(flush_all), .flush_nonglobal(flush_nonglobal),
        .wr_err(wr_err), .rd_err(rd_err), .mode_word(mode_word)
    );

    function automatic logic legal_ref(input logic [4:0] i);
        return (i == 0) || (i == 2) || (i == 3) || (i == 4) || (i == 8) || (i >= 16 && i <= 28);
    endfunction

    function automatic logic [31:0] mref(input logic lma, input logic pe, input logic pg,
                                         input logic [5:0] s);
        logic [2:0] sub;
        logic [1:0] dop, aop, dad, aad, stk;
        logic is64;
        if (lma) sub = s[0] ? 3'd4 : 3'd3;
        else if (!pe) sub = 3'd0;
        else sub = s[5] ? 3'd1 : 3'd2;
        is64 = (sub == 3'd4);
        dop = (is64 || s[1]) ? 2'd2 : 2'd1;
        aop = (is64 || s[1]) ? 2'd1 : 2'd2;
        dad = is64 ? 2'd3 : (s[1] ? 2'd2 : 2'd1);
        aad = is64 ? 2'd2 : (s[1] ? 2'd1 : 2'd2);
        stk = is64 ? 2'd3 : (s[4] ? 2'd2 : 2'd1);
        return {14'd0, stk, aad, dad, aop, dop, pe, pg, s[3:2], lma, sub};
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                        input logic [4:0] ri, input logic [31:0] erd,
                        input logic efa, input logic efn, input string tag);
        item_t it;
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_data = wd; rd_idx = ri; cyc_now = g_cyc;
        {vm_flag, ss_dsize, cs_dpl, cs_dsize, cs_long} = g_seg;
        it.tag = tag; it.rd = erd; it.fa = efa; it.fn = efn;
        it.we = we && !legal_ref(wi); it.re = !legal_ref(ri);
        q.push_back(it);
    endtask

    task automatic rd(input logic [4:0] ri, input logic [31:0] erd, input string tag);
        step(1'b0, 5'd0, 32'd0, ri, erd, 1'b0, 1'b0, tag);
    endtask

    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                it = q.pop_front();
                check(it.tag, "rd_data", rd_data, it.rd);
                check(it.tag, "flush_all", {31'd0, flush_all}, {31'd0, it.fa});
                check(it.tag, "flush_nonglobal", {31'd0, flush_nonglobal}, {31'd0, it.fn});
                check(it.tag, "wr_err", {31'd0, wr_err}, {31'd0, it.we});
                check(it.tag, "rd_err", {31'd0, rd_err}, {31'd0, it.re});
            end
        end
    end

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(5'd22, 32'hFFFF_0FF0, "R1 dr6 reset");
        rd(5'd23, 32'h0000_0400, "R1 dr7 reset");
        rd(5'd0, 32'd0, "R1 cr0 reset");
        rd(5'd28, mref(0, 0, 0, S0), "R1 R10 mode reset real");
        // R2: ET forced
        step(1, 5'd0, 32'h1, 5'd0, 32'h11, 0, 0, "R2 et forced");
        rd(5'd28, mref(0, 1, 0, S0), "R10 protected");
        step(1, 5'd24, 32'h100, 5'd24, 32'h100, 0, 0, "R2 set enable");
        step(1, 5'd0, 32'h8000_0001, 5'd24, 32'h500, 1, 0, "R2 R3 paging on activates");
        rd(5'd0, 32'h8000_0011, "R3 one-cycle pulse");
        g_seg = S64;
        rd(5'd28, mref(1, 1, 1, S64), "R10 R11 R12 64-bit");
        g_seg = SCOMP;
        rd(5'd28, mref(1, 1, 1, SCOMP), "R10 R11 compat");
        g_seg = S0;
        rd(5'd28, mref(1, 1, 1, S0), "R11 compat d clear");
        step(1, 5'd0, 32'h8000_0001, 5'd24, 32'h500, 0, 0, "R3 no toggle no flush");
        step(1, 5'd0, 32'h1, 5'd24, 32'h100, 1, 0, "R2 R3 paging off");
        step(1, 5'd24, 32'h0, 5'd24, 32'h0, 0, 0, "R2 clear enable");
        step(1, 5'd0, 32'h8000_0001, 5'd24, 32'h0, 1, 0, "R2 no enable no activate");
        // R4
        step(1, 5'd3, 32'h1234, 5'd3, 32'h1234, 0, 1, "R4 cr3 flush");
        step(1, 5'd3, 32'h1234, 5'd3, 32'h1234, 0, 1, "R4 cr3 same value");
        step(1, 5'd2, 32'hDEAD, 5'd2, 32'hDEAD, 0, 0, "R6 cr2 storage");
        step(1, 5'd8, 32'h7, 5'd8, 32'h7, 0, 0, "R6 cr8 storage");
        // R5
        step(1, 5'd4, 32'h10, 5'd4, 32'h10, 1, 0, "R5 pse toggle");
        step(1, 5'd4, 32'h11, 5'd4, 32'h11, 0, 0, "R5 other bit");
        step(1, 5'd4, 32'hB1, 5'd4, 32'hB1, 1, 0, "R5 pae pge toggle");
        // R6
        step(1, 5'd5, 32'hFF, 5'd9, 32'h0, 0, 0, "R6 illegal access");
        step(1, 5'd1, 32'h0, 5'd0, 32'h8000_0011, 0, 0, "R6 illegal no state");
        rd(5'd2, 32'hDEAD, "R6 no alias");
        rd(5'd30, 32'h0, "R6 high illegal");
        // R7
        step(1, 5'd20, 32'hFFFF_FFFF, 5'd22, 32'hFFFF_EFFF, 0, 0, "R7 dr4 alias mask");
        step(1, 5'd22, 32'h0, 5'd20, 32'hFFFF_0FF0, 0, 0, "R7 dr6 clear");
        step(1, 5'd21, 32'hFFFF_FFFF, 5'd23, 32'hFFFF_24FF, 0, 0, "R7 dr5 alias mask");
        step(1, 5'd23, 32'h0, 5'd21, 32'h0000_0400, 0, 0, "R7 dr7 clear");
        step(1, 5'd17, 32'hABCD, 5'd17, 32'hABCD, 0, 0, "R7 plain dr1");
        rd(5'd16, 32'h0, "R7 dr0 untouched");
        // R8
        g_cyc = 32'd100;
        step(1, 5'd25, 32'd1000, 5'd25, 32'd1000, 0, 0, "R8 tsc write");
        g_cyc = 32'd150;
        rd(5'd25, 32'd1050, "R8 tsc advance");
        g_cyc = 32'd10;
        step(1, 5'd25, 32'd5, 5'd25, 32'd5, 0, 0, "R8 tsc negative offset");
        g_cyc = 32'd20;
        rd(5'd25, 32'd15, "R8 tsc wrap");
        // R9
        step(1, 5'd26, 32'hFFFF, 5'd26, 32'hC7FF, 0, 0, "R9 fsw top zero");
        step(1, 5'd27, 32'h5, 5'd26, 32'hEFFF, 0, 0, "R9 fsw merge");
        step(1, 5'd27, 32'hFF, 5'd27, 32'h7, 0, 0, "R9 top width");
        // R12
        step(1, 5'd28, 32'hFFFF_FFFF, 5'd28, mref(0, 1, 1, S0), 0, 0, "R12 mode write discarded");
        rd(5'd0, 32'h8000_0011, "R12 cr0 unaffected");
        g_seg = SV86;
        rd(5'd28, mref(0, 1, 1, SV86), "R10 v86");
        step(1, 5'd0, 32'h0, 5'd28, mref(0, 0, 0, SV86), 1, 0, "R10 R3 real ignores vm");
        g_seg = S0;
        rd(5'd0, 32'h10, "R2 et with zero data");
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule